// File: doc/BRIEF.md
# Breaker Failure Detection Logic

This block decides that a circuit breaker has failed to clear a fault after protection has told it to open. When the initiate input is raised, the block at once repeats the trip command to the same breaker (re-trip). It then runs three independent delayed paths. Each path watches a different combination of conditions: the breaker's auxiliary contact, an external overcurrent comparator, and a switch that says the breaker is in service. When any path operates, the block raises a backup trip meant for every breaker around the faulted zone. It also latches a failure target flag.

The paths are ordered by speed. The early path needs the breaker still shown closed and fault current present. The main path needs fault current only, so it catches a breaker that opened mechanically but did not interrupt. The slow path checks no current at all and needs the breaker closed and in service. For the early and main paths, the current check starts on the high-set comparator. After a programmed breaker-opening interval it moves to the low-set comparator. Delays are counted in clock ticks, and the block works only on comparator result bits.

Top module: `bkr_fail_top`

## Requirements
- R1: `retrip_o` equals `init_i` in the same cycle, with no register delay.
- R2: Path 0 (early) uses bit 0 of the enable and operate vectors. It counts the clock edges seen while `init_i` is high, and its delay expires once that count reaches `dly_early_i`. `path_op_o[0]` is set at the next edge after a cycle in which the delay has expired, `aux_closed_i` is 1 and fault current is detected.
- R3: Path 1 (main) uses bit 1 and works like R2 against `dly_main_i`. It ignores `aux_closed_i` and operates on detected fault current alone.
- R4: For paths 0 and 1, fault current means `hiset_i` during the first `open_time_i` cycles after the path's delay expires, and `loset_i` from then on.
- R5: Path 2 (slow) uses bit 2 and works like R2 against `dly_slow_i`. It needs `aux_closed_i` and `in_service_i` both 1 and checks no current, so `in_service_i`=0 blocks it.
- R6: A path whose bit in `path_en_i` is 0 keeps its timer at zero. Its operate flag is clear one edge later and stays clear.
- R7: When `init_i` is low at an edge, every path timer and high/low stage goes back to idle and every operate flag clears.
- R8: `backup_trip_o` is 1 while any operate flag is set. It stays 1 for `seal_time_i` further cycles after the last flag clears.
- R9: `target_o` is set one edge after any operate flag is set. It stays set until `target_clr_i` is sampled high; the clear wins over a set in the same cycle.
- R10: Synchronous active-high `rst` clears all timers, operate flags, the seal-in and the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Breaker failure initiate from protection |
| aux_closed_i | input | 1 | Auxiliary contact: 1 = breaker closed |
| in_service_i | input | 1 | 1 = breaker in service |
| hiset_i | input | 1 | High-set overcurrent comparator result |
| loset_i | input | 1 | Low-set overcurrent comparator result |
| path_en_i | input | 3 | Per-path enable (bit 0 early, 1 main, 2 slow) |
| dly_early_i | input | DLY_W | Early path delay in ticks |
| dly_main_i | input | DLY_W | Main path delay in ticks |
| dly_slow_i | input | DLY_W | Slow path delay in ticks |
| open_time_i | input | DLY_W | Breaker-opening interval before low-set supervision |
| seal_time_i | input | SEAL_W | Backup trip seal-in length in ticks |
| target_clr_i | input | 1 | Clears the failure target |
| retrip_o | output | 1 | Re-trip to the initiated breaker |
| path_op_o | output | 3 | Per-path operate flags |
| backup_trip_o | output | 1 | Backup trip to the zone, sealed in |
| target_o | output | 1 | Latched failure target |

## Verification
A path timer that runs off by one shows up as an operate flag that rises one edge early or late. The bench compares that flag every cycle, so the error is seen on the very cycle the flag should change. A high/low stage stuck on the wrong comparator shows up as a missing or extra operation, seen once the opening interval has run out. A wrong seal-in count or a target that does not latch shows on `backup_trip_o` or `target_o`. That happens within the seal-in window after initiate drops, or at the first cycle after a clear.

// File: rtl/bf_pkg.sv
package bf_pkg;

    localparam int NUM_PATHS = 3;
    localparam int DEF_DLY_W = 16;

    // Supervision flavour of a delayed path
    typedef enum logic [1:0] {
        SUP_AUX_CUR = 2'd0,   // contact closed and current present
        SUP_CUR     = 2'd1,   // current present only
        SUP_AUX_SVC = 2'd2    // contact closed and breaker in service
    } sup_kind_e;

    // Sampled plant conditions shared by all paths
    typedef struct packed {
        logic init;
        logic aux_closed;
        logic in_service;
        logic hiset;
        logic loset;
    } sense_t;

    function automatic sup_kind_e kind_of(input int idx);
        case (idx)
            0:       return SUP_AUX_CUR;
            1:       return SUP_CUR;
            default: return SUP_AUX_SVC;
        endcase
    endfunction

    function automatic logic path_cond(input sup_kind_e k, input sense_t s, input logic cur);
        case (k)
            SUP_AUX_CUR: return s.aux_closed & cur;
            SUP_CUR:     return cur;
            default:     return s.aux_closed & s.in_service;
        endcase
    endfunction

endpackage

// File: rtl/bf_path.sv
module bf_path
    import bf_pkg::*;
#(
    parameter int        DLY_W = DEF_DLY_W,
    parameter sup_kind_e KIND  = SUP_AUX_CUR
) (
    input  logic             clk,
    input  logic             rst,
    input  sense_t           sense,
    input  logic             en,
    input  logic [DLY_W-1:0] dly,
    input  logic [DLY_W-1:0] open_time,
    output logic             op_o
);
    localparam logic [DLY_W-1:0] CNT_MAX = {DLY_W{1'b1}};
    localparam bit USES_CUR = (KIND != SUP_AUX_SVC);

    logic [DLY_W-1:0] elapsed;
    logic             run;
    logic             expired;
    logic             cur_seen;

    assign run     = sense.init & en;
    assign expired = run & (elapsed >= dly);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            elapsed <= '0;
        end else if (elapsed != CNT_MAX) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    generate
        if (USES_CUR) begin : g_cur
            logic [DLY_W-1:0] since;
            always_ff @(posedge clk) begin
                if (rst || !expired) begin
                    since <= '0;
                end else if (since != CNT_MAX) begin
                    since <= since + 1'b1;
                end
            end
            assign cur_seen = (since < open_time) ? sense.hiset : sense.loset;
        end else begin : g_nocur
            assign cur_seen = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            op_o <= 1'b0;
        end else if (expired && path_cond(KIND, sense, cur_seen)) begin
            op_o <= 1'b1;
        end
    end

endmodule

// File: rtl/bf_seal.sv
module bf_seal #(
    parameter int SEAL_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              any_op,
    input  logic [SEAL_W-1:0] seal_time,
    input  logic              clr,
    output logic              backup_o,
    output logic              target_o
);
    logic [SEAL_W-1:0] hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
        end else if (any_op) begin
            hold <= seal_time;
        end else if (hold != '0) begin
            hold <= hold - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            target_o <= 1'b0;
        end else if (any_op) begin
            target_o <= 1'b1;
        end
    end

    assign backup_o = any_op | (hold != '0);

endmodule

// File: rtl/bkr_fail_top.sv
module bkr_fail_top
    import bf_pkg::*;
#(
    parameter int DLY_W  = DEF_DLY_W,
    parameter int SEAL_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 init_i,
    input  logic                 aux_closed_i,
    input  logic                 in_service_i,
    input  logic                 hiset_i,
    input  logic                 loset_i,
    input  logic [NUM_PATHS-1:0] path_en_i,
    input  logic [DLY_W-1:0]     dly_early_i,
    input  logic [DLY_W-1:0]     dly_main_i,
    input  logic [DLY_W-1:0]     dly_slow_i,
    input  logic [DLY_W-1:0]     open_time_i,
    input  logic [SEAL_W-1:0]    seal_time_i,
    input  logic                 target_clr_i,
    output logic                 retrip_o,
    output logic [NUM_PATHS-1:0] path_op_o,
    output logic                 backup_trip_o,
    output logic                 target_o
);
    sense_t           sense;
    logic [DLY_W-1:0] dly_arr [NUM_PATHS];

    assign sense = '{init:       init_i,
                     aux_closed: aux_closed_i,
                     in_service: in_service_i,
                     hiset:      hiset_i,
                     loset:      loset_i};

    assign dly_arr[0] = dly_early_i;
    assign dly_arr[1] = dly_main_i;
    assign dly_arr[2] = dly_slow_i;

    assign retrip_o = init_i;

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        bf_path #(
            .DLY_W (DLY_W),
            .KIND  (kind_of(p))
        ) u_path (
            .clk       (clk),
            .rst       (rst),
            .sense     (sense),
            .en        (path_en_i[p]),
            .dly       (dly_arr[p]),
            .open_time (open_time_i),
            .op_o      (path_op_o[p])
        );
    end

    bf_seal #(.SEAL_W(SEAL_W)) u_seal (
        .clk       (clk),
        .rst       (rst),
        .any_op    (|path_op_o),
        .seal_time (seal_time_i),
        .clr       (target_clr_i),
        .backup_o  (backup_trip_o),
        .target_o  (target_o)
    );

endmodule

// File: rtl/bkr_fail_chk.sv
module bkr_fail_chk (
    input logic       clk,
    input logic       rst,
    input logic       init_i,
    input logic       aux_closed_i,
    input logic       in_service_i,
    input logic [2:0] path_en_i,
    input logic       target_clr_i,
    input logic       retrip_o,
    input logic [2:0] path_op_o,
    input logic       backup_trip_o,
    input logic       target_o
);
    assert_retrip_R1: assert property (@(posedge clk) disable iff (rst)
        retrip_o == init_i);

    assert_early_aux_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(path_op_o[0]) |-> $past(aux_closed_i));

    assert_slow_svc_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(path_op_o[2]) |-> ($past(aux_closed_i) && $past(in_service_i)));

    assert_off_early_R6: assert property (@(posedge clk) disable iff (rst)
        !path_en_i[0] |=> !path_op_o[0]);
    assert_off_main_R6: assert property (@(posedge clk) disable iff (rst)
        !path_en_i[1] |=> !path_op_o[1]);
    assert_off_slow_R6: assert property (@(posedge clk) disable iff (rst)
        !path_en_i[2] |=> !path_op_o[2]);

    assert_drop_R7: assert property (@(posedge clk) disable iff (rst)
        !init_i |=> (path_op_o == 3'b000));

    assert_backup_R8: assert property (@(posedge clk) disable iff (rst)
        (path_op_o != 3'b000) |-> backup_trip_o);

    assert_target_R9: assert property (@(posedge clk) disable iff (rst)
        ((path_op_o != 3'b000) && !target_clr_i) |=> target_o);

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        target_clr_i |=> !target_o);
endmodule

bind bkr_fail_top bkr_fail_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .init_i        (init_i),
    .aux_closed_i  (aux_closed_i),
    .in_service_i  (in_service_i),
    .path_en_i     (path_en_i),
    .target_clr_i  (target_clr_i),
    .retrip_o      (retrip_o),
    .path_op_o     (path_op_o),
    .backup_trip_o (backup_trip_o),
    .target_o      (target_o)
);

// File: tb/bkr_fail_top_test.sv
`timescale 1ns/1ps
module bkr_fail_top_test;
    localparam int DW = 16;
    localparam int SW = 16;
    localparam int D_EARLY = 3, D_MAIN = 5, D_SLOW = 8, OPEN_T = 2, SEAL_T = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          init_i = 0, aux_closed_i = 0, in_service_i = 0, hiset_i = 0, loset_i = 0;
    logic [2:0]    path_en_i = 3'b111;
    logic          target_clr_i = 0;
    logic          retrip_o, backup_trip_o, target_o;
    logic [2:0]    path_op_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    string req   = "R10";

    always #5 clk = ~clk;

    bkr_fail_top #(.DLY_W(DW), .SEAL_W(SW)) uut (
        .clk(clk), .rst(rst), .init_i(init_i), .aux_closed_i(aux_closed_i),
        .in_service_i(in_service_i), .hiset_i(hiset_i), .loset_i(loset_i),
        .path_en_i(path_en_i),
        .dly_early_i(DW'(D_EARLY)), .dly_main_i(DW'(D_MAIN)), .dly_slow_i(DW'(D_SLOW)),
        .open_time_i(DW'(OPEN_T)), .seal_time_i(SW'(SEAL_T)),
        .target_clr_i(target_clr_i), .retrip_o(retrip_o), .path_op_o(path_op_o),
        .backup_trip_o(backup_trip_o), .target_o(target_o)
    );

    // Behavioural reference: tick counts and flags kept as integers
    int ticks [3];
    bit m_op  [3];
    int m_seal;
    bit m_tgt;
    int delays [3] = '{D_EARLY, D_MAIN, D_SLOW};

    always @(posedge clk) begin
        bit was_any, live, timed_out, current, ok;
        int since;
        if (rst) begin
            for (int p = 0; p < 3; p++) begin ticks[p] = 0; m_op[p] = 0; end
            m_seal = 0;
            m_tgt  = 0;
        end else begin
            was_any = m_op[0] | m_op[1] | m_op[2];
            for (int p = 0; p < 3; p++) begin
                live      = init_i && path_en_i[p];
                timed_out = live && (ticks[p] >= delays[p]);
                since     = ticks[p] - delays[p];
                current   = (since < OPEN_T) ? hiset_i : loset_i;
                if (p == 0)      ok = aux_closed_i && current;
                else if (p == 1) ok = current;
                else             ok = aux_closed_i && in_service_i;
                m_op[p]  = live && (m_op[p] || (timed_out && ok));
                ticks[p] = live ? ticks[p] + 1 : 0;
            end
            m_seal = was_any ? SEAL_T : ((m_seal > 0) ? m_seal - 1 : 0);
            m_tgt  = target_clr_i ? 1'b0 : (m_tgt | was_any);
        end
    end

    task automatic check(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0d exp=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check("retrip (R1)", retrip_o, init_i);
            check("path_op", path_op_o, {m_op[2], m_op[1], m_op[0]});
            check("backup (R8)", backup_trip_o, (m_op[0] | m_op[1] | m_op[2]) || (m_seal > 0));
            check("target (R9)", target_o, m_tgt);
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        init_i = 0; aux_closed_i = 0; in_service_i = 0; hiset_i = 0; loset_i = 0;
        path_en_i = 3'b111;
    endtask

    initial begin
        tick(3);
        req = "R10";  // reset state
        check("reset path_op R10", path_op_o, 0);
        check("reset target R10", target_o, 0);
        rst = 0;
        tick(2);

        req = "R2";   // early path: contact closed and high-set current
        aux_closed_i = 1; hiset_i = 1; init_i = 1;
        tick(D_EARLY);
        check("early not yet R2", path_op_o[0], 0);
        tick(1);
        check("early operates R2", path_op_o[0], 1);
        tick(8);
        quiet();
        tick(SEAL_T + 3);

        req = "R9";   // clear the latched target
        target_clr_i = 1; tick(1); target_clr_i = 0;
        check("target cleared R9", target_o, 0);
        tick(2);

        req = "R3";   // contact open: only the main path can operate
        hiset_i = 1; init_i = 1;
        tick(D_MAIN + 1);
        check("main operates R3", path_op_o, 3'b010);
        tick(3);
        quiet();
        tick(SEAL_T + 3);

        req = "R4";   // high-set absent, low-set present: waits for opening interval
        path_en_i = 3'b010; loset_i = 1; init_i = 1;
        tick(D_MAIN + OPEN_T);
        check("still on high-set R4", path_op_o[1], 0);
        tick(1);
        check("low-set takes over R4", path_op_o[1], 1);
        quiet(); tick(SEAL_T + 3);
        path_en_i = 3'b010; hiset_i = 1; init_i = 1;   // high-set only, gone after interval
        tick(D_MAIN);
        hiset_i = 0;
        tick(6);
        check("no op after high-set gone R4", path_op_o[1], 0);
        quiet(); tick(3);

        req = "R5";   // slow path: out of service blocks, in service operates
        path_en_i = 3'b100; aux_closed_i = 1; init_i = 1;
        tick(D_SLOW + 4);
        check("out of service blocks R5", path_op_o[2], 0);
        in_service_i = 1;
        tick(1);
        check("in service operates R5", path_op_o[2], 1);
        quiet(); tick(SEAL_T + 3);

        req = "R6";   // all paths disabled
        path_en_i = 3'b000; aux_closed_i = 1; in_service_i = 1; hiset_i = 1; loset_i = 1;
        init_i = 1;
        tick(D_SLOW + 6);
        check("disabled never operates R6", path_op_o, 0);
        path_en_i = 3'b001;
        tick(D_EARLY + 1);
        check("timer started from zero R6", path_op_o[0], 1);
        quiet(); tick(SEAL_T + 3);

        req = "R7";   // initiate drops before any delay expires
        aux_closed_i = 1; in_service_i = 1; hiset_i = 1; init_i = 1;
        tick(2);
        init_i = 0;
        tick(1);
        init_i = 1;
        tick(D_EARLY);
        check("timers restarted R7", path_op_o, 0);
        tick(1);
        check("early after restart R7", path_op_o[0], 1);
        init_i = 0;
        tick(1);
        req = "R8";
        check("flags cleared, seal holds R8", {path_op_o, backup_trip_o}, 4'b0001);
        tick(SEAL_T);
        check("seal expired R8", backup_trip_o, 0);
        quiet(); tick(2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule